// File: doc/BRIEF.md
# TLB Invalid-Entry Exception Entry Sequencer

This block performs the hardware half of entering an exception when the address
translation unit reports that the matching translation entry is not valid. When
a fault request is presented, it captures the architectural state the handler
needs on a single clock edge. That state is the page number and the full
faulting address, a cause code that tells a load from a store, the return
address and the prior status word. On the same edge it raises the privilege,
bank-select and exception-block bits of the status word, and for one cycle it
drives a fetch redirect to the handler entry point. The handler entry point is
the vector base plus a fixed offset.

The block also guards against a fault that arrives while the status word
already blocks exceptions. Such a request is reported as a double fault. It
leaves every saved register unchanged and does not redirect fetch. Instruction
decode, the return-from-exception path and the handler software belong to
other blocks.

Top module: `tlb_fault_entry`

## Requirements
- R1: On an accepted fault, `pteh_vpn` takes the faulting address bits [31:10] (the virtual page number).
- R2: On an accepted fault, `tea` takes the full faulting virtual address.
- R3: On an accepted fault, `expcode` becomes 0x040 when `fault_is_store` is 0 (load) and 0x060 when it is 1 (store).
- R4: On an accepted fault, `spc` takes `cur_pc`, or takes `branch_pc` when `in_delay_slot` is 1.
- R5: On an accepted fault, `ssr` takes the value of `sr_in` as presented, with no status bit changed.
- R6: On an accepted fault, `sr_out` equals `sr_in` with bits 30 (privileged mode), 29 (register bank) and 28 (exception block) forced to 1 and all other bits unchanged.
- R7: On an accepted fault, `redirect` is high for exactly one cycle and `redirect_pc` equals `vbr_in` + 0x100, modulo 2^32.
- R8: A request sampled high on a clock edge updates all outputs on that same edge, with no further delay. Requests on consecutive cycles each commit in turn.
- R9: A request while `sr_in` bit 28 is 1 pulses `dbl_fault` for one cycle. It leaves `pteh_vpn`, `tea`, `expcode`, `spc`, `ssr` and `sr_out` unchanged and keeps `redirect` low.
- R10: While `rst_n` is low, every output is 0.
- R11: With no request, every captured output holds its value and `redirect` and `dbl_fault` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 1 | Invalid-entry fault reported this cycle |
| fault_va | input | 32 | Faulting virtual address |
| fault_is_store | input | 1 | 1 = store access, 0 = load access |
| cur_pc | input | 32 | Address of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction sits in a delay slot |
| branch_pc | input | 32 | Address of the delayed branch |
| sr_in | input | 32 | Current status word |
| vbr_in | input | 32 | Vector base |
| pteh_vpn | output | 22 | Captured virtual page number |
| tea | output | 32 | Captured faulting address |
| expcode | output | 12 | Exception cause code |
| spc | output | 32 | Saved return address |
| ssr | output | 32 | Saved status word |
| sr_out | output | 32 | New status word |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | Handler fetch address |
| dbl_fault | output | 1 | One-cycle double-fault pulse |

## Verification
The assertions assume that `sr_in` and `vbr_in` are stable and valid in the cycle
a request is sampled. They also assume that `fault_req` is low throughout reset,
so that the hold and double-fault checks compare against values captured after
reset. The bench changes inputs only on the falling clock edge and keeps
`fault_req` low during reset. It holds every other input steady for the whole
cycle in which a request is presented.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int unsigned CODE_W     = 12;
    localparam logic [CODE_W-1:0] CODE_LOAD  = 12'h040;
    localparam logic [CODE_W-1:0] CODE_STORE = 12'h060;
    typedef enum logic { ACC_LOAD = 1'b0, ACC_STORE = 1'b1 } access_e;
endpackage

// File: rtl/tlbx_cause_enc.sv
module tlbx_cause_enc
    import tlbx_pkg::*;
#(
    parameter int unsigned A_W = 32
) (
    input  access_e            acc,
    input  logic               in_ds,
    input  logic [A_W-1:0]     inst_pc,
    input  logic [A_W-1:0]     br_pc,
    output logic [CODE_W-1:0]  code,
    output logic [A_W-1:0]     ret_pc
);
    always_comb begin
        code   = (acc == ACC_STORE) ? CODE_STORE : CODE_LOAD;
        ret_pc = in_ds ? br_pc : inst_pc;
    end
endmodule

// File: rtl/tlbx_sr_mod.sv
module tlbx_sr_mod #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] SET_MASK = '0
) (
    input  logic [W-1:0] sr_old,
    output logic [W-1:0] sr_new
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (SET_MASK[i]) begin : g_force
            assign sr_new[i] = 1'b1;
        end else begin : g_keep
            assign sr_new[i] = sr_old[i];
        end
    end
endmodule

// File: rtl/tlbx_vec_calc.sv
module tlbx_vec_calc #(
    parameter int unsigned A_W = 32,
    parameter logic [A_W-1:0] OFS = 'h100
) (
    input  logic [A_W-1:0] base,
    output logic [A_W-1:0] target
);
    assign target = base + OFS;
endmodule

// File: rtl/tlb_fault_entry.sv
module tlb_fault_entry
    import tlbx_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_BITS = 10,
    parameter int unsigned MD_BIT    = 30,
    parameter int unsigned RB_BIT    = 29,
    parameter int unsigned BL_BIT    = 28,
    parameter logic [31:0] VEC_OFS   = 32'h100,
    localparam int unsigned VPN_W    = VA_W - PAGE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fault_req,
    input  logic [VA_W-1:0]     fault_va,
    input  logic                fault_is_store,
    input  logic [VA_W-1:0]     cur_pc,
    input  logic                in_delay_slot,
    input  logic [VA_W-1:0]     branch_pc,
    input  logic [31:0]         sr_in,
    input  logic [VA_W-1:0]     vbr_in,
    output logic [VPN_W-1:0]    pteh_vpn,
    output logic [VA_W-1:0]     tea,
    output logic [CODE_W-1:0]   expcode,
    output logic [VA_W-1:0]     spc,
    output logic [31:0]         ssr,
    output logic [31:0]         sr_out,
    output logic                redirect,
    output logic [VA_W-1:0]     redirect_pc,
    output logic                dbl_fault
);
    localparam logic [31:0] SR_SET =
        (32'd1 << MD_BIT) | (32'd1 << RB_BIT) | (32'd1 << BL_BIT);

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VA_W-1:0]   tea;
        logic [CODE_W-1:0] code;
        logic [VA_W-1:0]   spc;
        logic [31:0]       ssr;
        logic [31:0]       sr;
        logic [VA_W-1:0]   tgt;
        logic              redir;
        logic              dbl;
    } state_t;

    state_t st_d, st_q;

    logic [CODE_W-1:0] code_w;
    logic [VA_W-1:0]   ret_pc_w;
    logic [31:0]       sr_new_w;
    logic [VA_W-1:0]   tgt_w;
    logic              blocked_w;
    logic              take_w;

    tlbx_cause_enc #(.A_W(VA_W)) u_cause (
        .acc     (access_e'(fault_is_store)),
        .in_ds   (in_delay_slot),
        .inst_pc (cur_pc),
        .br_pc   (branch_pc),
        .code    (code_w),
        .ret_pc  (ret_pc_w)
    );

    tlbx_sr_mod #(.W(32), .SET_MASK(SR_SET)) u_sr (
        .sr_old (sr_in),
        .sr_new (sr_new_w)
    );

    tlbx_vec_calc #(.A_W(VA_W), .OFS(VEC_OFS[VA_W-1:0])) u_vec (
        .base   (vbr_in),
        .target (tgt_w)
    );

    assign blocked_w = sr_in[BL_BIT];
    assign take_w    = fault_req & ~blocked_w;

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        st_d.dbl   = fault_req & blocked_w;
        if (take_w) begin
            st_d.vpn   = fault_va[VA_W-1:PAGE_BITS];
            st_d.tea   = fault_va;
            st_d.code  = code_w;
            st_d.spc   = ret_pc_w;
            st_d.ssr   = sr_in;
            st_d.sr    = sr_new_w;
            st_d.tgt   = tgt_w;
            st_d.redir = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pteh_vpn    = st_q.vpn;
    assign tea         = st_q.tea;
    assign expcode     = st_q.code;
    assign spc         = st_q.spc;
    assign ssr         = st_q.ssr;
    assign sr_out      = st_q.sr;
    assign redirect    = st_q.redir;
    assign redirect_pc = st_q.tgt;
    assign dbl_fault   = st_q.dbl;

    // R7
    vec_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> redirect_pc == $past(vbr_in) + VEC_OFS[VA_W-1:0]);

    // R5
    ssr_prior_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ssr == $past(sr_in));

    // R6
    sr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (sr_out[MD_BIT] && sr_out[RB_BIT] && sr_out[BL_BIT]));

    // R3
    code_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (expcode == CODE_LOAD || expcode == CODE_STORE));

    // R9
    dbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_fault |-> ($stable(spc) && $stable(ssr) && $stable(tea) && !redirect));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redirect, dbl_fault}));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fault_req) |-> ($stable(tea) && !redirect && !dbl_fault));
endmodule

// File: tb/sim_tlb_fault_entry.sv
`timescale 1ns/1ps
module sim_tlb_fault_entry;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_req = 1'b0;
    logic [31:0] fault_va = '0;
    logic        fault_is_store = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        in_delay_slot = 1'b0;
    logic [31:0] branch_pc = '0;
    logic [31:0] sr_in = '0;
    logic [31:0] vbr_in = '0;
    logic [21:0] pteh_vpn;
    logic [31:0] tea, spc, ssr, sr_out, redirect_pc;
    logic [11:0] expcode;
    logic        redirect, dbl_fault;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tlb_fault_entry u0 (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .fault_va(fault_va),
        .fault_is_store(fault_is_store), .cur_pc(cur_pc),
        .in_delay_slot(in_delay_slot), .branch_pc(branch_pc), .sr_in(sr_in),
        .vbr_in(vbr_in), .pteh_vpn(pteh_vpn), .tea(tea), .expcode(expcode),
        .spc(spc), .ssr(ssr), .sr_out(sr_out), .redirect(redirect),
        .redirect_pc(redirect_pc), .dbl_fault(dbl_fault)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        st;
        logic [31:0] pc;
        logic        ds;
        logic [31:0] bpc;
        logic [31:0] sr;
        logic [31:0] vbr;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5678, 1'b0, 32'h8C00_1000, 1'b0, 32'h8C00_0FFE, 32'h0000_00F0, 32'h8C00_0000},
        '{32'hFFFF_FC00, 1'b1, 32'h0000_1002, 1'b1, 32'h0000_0FFC, 32'h6000_03F0, 32'h0000_0000},
        '{32'h0000_0000, 1'b0, 32'h0000_0004, 1'b1, 32'h0000_0002, 32'h0000_0000, 32'hFFFF_FF00},
        '{32'h8000_03FF, 1'b1, 32'hA000_0000, 1'b0, 32'h0000_0000, 32'h8FFF_FFFF, 32'h1234_0000}
    };

    localparam logic [31:0] SET_BITS = 32'h7000_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        fault_va = v.va; fault_is_store = v.st; cur_pc = v.pc;
        in_delay_slot = v.ds; branch_pc = v.bpc; sr_in = v.sr; vbr_in = v.vbr;
        fault_req = 1'b1;
    endtask

    task automatic check_commit(input vec_t v);
        chk("R1 vpn", {10'd0, pteh_vpn}, {10'd0, v.va[31:10]});
        chk("R2 tea", tea, v.va);
        chk("R3 code", {20'd0, expcode}, v.st ? 32'h60 : 32'h40);
        chk("R4 spc", spc, v.ds ? v.bpc : v.pc);
        chk("R5 ssr", ssr, v.sr);
        chk("R6 sr_out", sr_out, v.sr | SET_BITS);
        chk("R7 redirect", {31'd0, redirect}, 32'd1);
        chk("R7 target", redirect_pc, v.vbr + 32'h100);
        chk("R9 no dbl", {31'd0, dbl_fault}, 32'd0);
    endtask

    initial begin : watchdog
        #(5ns * 5000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        vec_t last;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 tea", tea, 32'd0);
        chk("R10 spc", spc, 32'd0);
        chk("R10 sr_out", sr_out, 32'd0);
        chk("R10 pulses", {30'd0, redirect, dbl_fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            fault_req = 1'b0;
            check_commit(VECS[i]);      // R8 committed on the single edge
            @(negedge clk);
            chk("R7 one cycle", {31'd0, redirect}, 32'd0);
            chk("R11 hold tea", tea, VECS[i].va);
        end
        last = VECS[NV-1];

        // R11 idle with changing inputs
        fault_va = 32'hDEAD_BEEF; sr_in = 32'h0; vbr_in = 32'h5555_0000;
        repeat (3) @(negedge clk);
        chk("R11 idle tea", tea, last.va);
        chk("R11 idle target", redirect_pc, last.vbr + 32'h100);
        chk("R11 idle pulses", {30'd0, redirect, dbl_fault}, 32'd0);

        // R9 double fault
        drive('{32'h0BAD_0000, 1'b0, 32'h0000_7770, 1'b0, 32'h0, 32'h1000_0000, 32'h9999_0000});
        @(negedge clk);
        fault_req = 1'b0;
        chk("R9 dbl pulse", {31'd0, dbl_fault}, 32'd1);
        chk("R9 no redirect", {31'd0, redirect}, 32'd0);
        chk("R9 spc held", spc, last.pc);
        chk("R9 ssr held", ssr, last.sr);
        chk("R9 tea held", tea, last.va);
        chk("R9 vpn held", {10'd0, pteh_vpn}, {10'd0, last.va[31:10]});
        chk("R9 code held", {20'd0, expcode}, 32'h60);
        chk("R9 sr held", sr_out, last.sr | SET_BITS);
        @(negedge clk);
        chk("R9 dbl one cycle", {31'd0, dbl_fault}, 32'd0);

        // R8 back-to-back requests
        drive(VECS[0]);
        @(negedge clk);
        check_commit(VECS[0]);
        drive(VECS[1]);
        @(negedge clk);
        fault_req = 1'b0;
        check_commit(VECS[1]);
        @(negedge clk);
        chk("R8 pulse ends", {31'd0, redirect}, 32'd0);

        // R10 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 clear vpn", {10'd0, pteh_vpn}, 32'd0);
        chk("R10 clear ssr", ssr, 32'd0);
        chk("R10 clear target", redirect_pc, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule